// File: doc/BRIEF.md
# Compressed Page Writeback Overflow Manager

The block handles one cache-line writeback into a page stored in a linear compressed layout. Every line of such a page has a fixed-size slot in the compressed region. A line that no longer fits its slot is moved to a small overflow region placed after the page metadata. The metadata holds one valid bit per overflow slot and an array that records which line each overflow slot holds.

For each request the block takes the line number, the size the compressor produced, the page and slot size classes, and the current metadata. It picks the destination: the regular slot, the overflow slot the line already owns, or a newly allocated overflow slot. It returns the page-relative byte offset of the write, the updated metadata with a write strobe, and an exception when the line needs an overflow slot and none is free.

All results are registered. They appear one cycle after the request.

Top module: `lcp_wb_ovf`

## Requirements
- R1: A line whose compressed size is at most the slot size (slot bytes = 4 << slot_cls_i) is written to its regular slot. In that case dest_o = 1 and wr_off_o = line_idx_i * slot bytes.
- R2: On a regular-slot write, an existing overflow entry for that line has its valid bit cleared and meta_we_o = 1. Without such an entry the bitmap is returned unchanged and meta_we_o = 0.
- R3: A line that does not fit and already owns overflow slot k is rewritten there. In that case dest_o = 2, wr_off_o = overflow base + 64*k, the metadata is unchanged and meta_we_o = 0. The overflow base is 64*(slot bytes) + 64.
- R4: A line that does not fit and owns no overflow slot gets the lowest-numbered free slot k. Its valid bit is set, the line number is written into index entry k (bits [6k +: 6] of ovf_idx_o), and the data is written there. The outputs are dest_o = 3 and meta_we_o = 1.
- R5: When an overflow slot is needed and none is free, exc_o = 1, wr_en_o = 0 and meta_we_o = 0.
- R6: The number of usable overflow slots is computed as min(8, max(0, (page bytes - 64*slot bytes - 64) / 64)), where page bytes = 512 << page_cls_i. Bitmap bits and index entries at or above that count are never matched and never allocated.
- R7: Results appear on the outputs one clock after req_valid_i is sampled high. In a cycle after no request, wr_en_o, meta_we_o and exc_o are 0 and dest_o = 0.
- R8: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Writeback request this cycle |
| line_idx_i | input | 6 | Line number within the page |
| comp_size_i | input | 7 | Compressed size of the line in bytes (0..64) |
| page_cls_i | input | 2 | Page size class: 512 << code bytes |
| slot_cls_i | input | 2 | Slot size class: 4 << code bytes |
| ovf_valid_i | input | 8 | Current overflow valid bitmap |
| ovf_idx_i | input | 48 | Current index array, 6 bits per slot |
| wr_en_o | output | 1 | Data write strobe |
| dest_o | output | 2 | 0 none, 1 regular, 2 owned overflow slot, 3 new overflow slot |
| wr_off_o | output | 12 | Byte offset of the write within the page |
| meta_we_o | output | 1 | Metadata write strobe |
| ovf_valid_o | output | 8 | Updated overflow valid bitmap |
| ovf_idx_o | output | 48 | Updated index array |
| exc_o | output | 1 | Overflow region full |

## Verification
The assertions assume that the metadata presented with a request is consistent. No two valid index entries may name the same line, because the owned-slot search then returns a single slot. The bench builds every metadata pattern by hand to respect this, including a pattern with stale bits beyond the usable slot count. Because the assertions on bitmap population compare against the inputs one cycle back, the bench holds inputs only for the request cycle and reads results in the following low clock phase.

// File: rtl/lcp_wb_pkg.sv
package lcp_wb_pkg;
  typedef enum logic [1:0] {
    DST_NONE    = 2'd0,
    DST_REG     = 2'd1,
    DST_OVF_HIT = 2'd2,
    DST_OVF_NEW = 2'd3
  } dest_e;
endpackage

// File: rtl/lcp_ovf_geom.sv
module lcp_ovf_geom #(
  parameter int LINES          = 64,
  parameter int LINE_BYTES     = 64,
  parameter int META_BYTES     = 64,
  parameter int MAX_OVF        = 8,
  parameter int MIN_PAGE_BYTES = 512,
  parameter int MIN_SLOT_BYTES = 4,
  localparam int SLOT_W        = $clog2(MAX_OVF),
  localparam int SIZE_W        = $clog2(LINE_BYTES) + 1,
  localparam int OFF_W         = $clog2(MIN_PAGE_BYTES) + 3
) (
  input  logic [1:0]        page_cls_i,
  input  logic [1:0]        slot_cls_i,
  output logic [SLOT_W:0]   n_slots_o,
  output logic [SIZE_W-1:0] slot_bytes_o,
  output logic [OFF_W-1:0]  ovf_base_o
);
  always_comb begin
    int page_b, slot_b, comp_b, spare, cnt;
    page_b = MIN_PAGE_BYTES << page_cls_i;
    slot_b = MIN_SLOT_BYTES << slot_cls_i;
    comp_b = LINES * slot_b;
    spare  = page_b - comp_b - META_BYTES;
    cnt    = (spare > 0) ? spare / LINE_BYTES : 0;
    if (cnt > MAX_OVF) cnt = MAX_OVF;
    n_slots_o    = (SLOT_W+1)'(cnt);
    slot_bytes_o = SIZE_W'(slot_b);
    ovf_base_o   = OFF_W'(comp_b + META_BYTES);
  end
endmodule

// File: rtl/lcp_ovf_lookup.sv
module lcp_ovf_lookup #(
  parameter int LIDX_W  = 6,
  parameter int MAX_OVF = 8,
  localparam int SLOT_W = $clog2(MAX_OVF)
) (
  input  logic [LIDX_W-1:0]         line_idx_i,
  input  logic [SLOT_W:0]           n_slots_i,
  input  logic [MAX_OVF-1:0]        ovf_valid_i,
  input  logic [MAX_OVF*LIDX_W-1:0] ovf_idx_i,
  output logic                      hit_o,
  output logic [SLOT_W-1:0]         hit_slot_o,
  output logic                      free_o,
  output logic [SLOT_W-1:0]         free_slot_o
);
  logic [MAX_OVF-1:0] hit_vec, free_vec;

  for (genvar k = 0; k < MAX_OVF; k++) begin : g_slot
    logic in_range;
    assign in_range    = n_slots_i > (SLOT_W+1)'(k);
    assign hit_vec[k]  = in_range && ovf_valid_i[k] &&
                         (ovf_idx_i[k*LIDX_W +: LIDX_W] == line_idx_i);
    assign free_vec[k] = in_range && !ovf_valid_i[k];
  end

  // lowest index wins; hit_vec is at most one-hot for consistent metadata
  always_comb begin
    hit_o       = 1'b0;
    hit_slot_o  = '0;
    free_o      = 1'b0;
    free_slot_o = '0;
    for (int k = MAX_OVF - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        hit_o      = 1'b1;
        hit_slot_o = SLOT_W'(k);
      end
      if (free_vec[k]) begin
        free_o      = 1'b1;
        free_slot_o = SLOT_W'(k);
      end
    end
  end
endmodule

// File: rtl/lcp_wb_ovf.sv
module lcp_wb_ovf #(
  parameter int LINES          = 64,
  parameter int LINE_BYTES     = 64,
  parameter int META_BYTES     = 64,
  parameter int MAX_OVF        = 8,
  parameter int MIN_PAGE_BYTES = 512,
  parameter int MIN_SLOT_BYTES = 4,
  localparam int LIDX_W        = $clog2(LINES),
  localparam int SIZE_W        = $clog2(LINE_BYTES) + 1,
  localparam int OFF_W         = $clog2(MIN_PAGE_BYTES) + 3,
  localparam int SLOT_W        = $clog2(MAX_OVF)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [LIDX_W-1:0]         line_idx_i,
  input  logic [SIZE_W-1:0]         comp_size_i,
  input  logic [1:0]                page_cls_i,
  input  logic [1:0]                slot_cls_i,
  input  logic [MAX_OVF-1:0]        ovf_valid_i,
  input  logic [MAX_OVF*LIDX_W-1:0] ovf_idx_i,
  output logic                      wr_en_o,
  output logic [1:0]                dest_o,
  output logic [OFF_W-1:0]          wr_off_o,
  output logic                      meta_we_o,
  output logic [MAX_OVF-1:0]        ovf_valid_o,
  output logic [MAX_OVF*LIDX_W-1:0] ovf_idx_o,
  output logic                      exc_o
);
  import lcp_wb_pkg::*;

  logic [SLOT_W:0]   n_slots;
  logic [SIZE_W-1:0] slot_bytes;
  logic [OFF_W-1:0]  ovf_base;
  logic              hit, free;
  logic [SLOT_W-1:0] hit_slot, free_slot;

  lcp_ovf_geom #(
    .LINES(LINES), .LINE_BYTES(LINE_BYTES), .META_BYTES(META_BYTES),
    .MAX_OVF(MAX_OVF), .MIN_PAGE_BYTES(MIN_PAGE_BYTES),
    .MIN_SLOT_BYTES(MIN_SLOT_BYTES)
  ) u_geom (
    .page_cls_i  (page_cls_i),
    .slot_cls_i  (slot_cls_i),
    .n_slots_o   (n_slots),
    .slot_bytes_o(slot_bytes),
    .ovf_base_o  (ovf_base)
  );

  lcp_ovf_lookup #(.LIDX_W(LIDX_W), .MAX_OVF(MAX_OVF)) u_lookup (
    .line_idx_i (line_idx_i),
    .n_slots_i  (n_slots),
    .ovf_valid_i(ovf_valid_i),
    .ovf_idx_i  (ovf_idx_i),
    .hit_o      (hit),
    .hit_slot_o (hit_slot),
    .free_o     (free),
    .free_slot_o(free_slot)
  );

  logic                      fits;
  dest_e                     dest_d;
  logic                      wr_en_d, meta_we_d, exc_d;
  logic [OFF_W-1:0]          off_d;
  logic [MAX_OVF-1:0]        valid_d;
  logic [MAX_OVF*LIDX_W-1:0] idx_d;

  assign fits = comp_size_i <= slot_bytes;

  always_comb begin
    dest_d    = DST_NONE;
    wr_en_d   = 1'b0;
    meta_we_d = 1'b0;
    exc_d     = 1'b0;
    off_d     = '0;
    valid_d   = ovf_valid_i;
    idx_d     = ovf_idx_i;
    if (fits) begin
      dest_d  = DST_REG;
      wr_en_d = 1'b1;
      off_d   = OFF_W'(line_idx_i) * OFF_W'(slot_bytes);
      if (hit) begin
        valid_d[hit_slot] = 1'b0;
        meta_we_d         = 1'b1;
      end
    end else if (hit) begin
      dest_d  = DST_OVF_HIT;
      wr_en_d = 1'b1;
      off_d   = ovf_base + OFF_W'(hit_slot) * OFF_W'(LINE_BYTES);
    end else if (free) begin
      dest_d                               = DST_OVF_NEW;
      wr_en_d                              = 1'b1;
      meta_we_d                            = 1'b1;
      off_d                                = ovf_base + OFF_W'(free_slot) * OFF_W'(LINE_BYTES);
      valid_d[free_slot]                   = 1'b1;
      idx_d[free_slot*LIDX_W +: LIDX_W]    = line_idx_i;
    end else begin
      exc_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o     <= 1'b0;
      dest_o      <= 2'd0;
      wr_off_o    <= '0;
      meta_we_o   <= 1'b0;
      ovf_valid_o <= '0;
      ovf_idx_o   <= '0;
      exc_o       <= 1'b0;
    end else if (req_valid_i) begin
      wr_en_o     <= wr_en_d;
      dest_o      <= dest_d;
      wr_off_o    <= off_d;
      meta_we_o   <= meta_we_d;
      ovf_valid_o <= valid_d;
      ovf_idx_o   <= idx_d;
      exc_o       <= exc_d;
    end else begin
      wr_en_o   <= 1'b0;
      dest_o    <= 2'd0;
      meta_we_o <= 1'b0;
      exc_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/lcp_wb_ovf_chk.sv
module lcp_wb_ovf_chk #(
  parameter int MAX_OVF = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [MAX_OVF-1:0] ovf_valid_i,
  input logic               wr_en_o,
  input logic [1:0]         dest_o,
  input logic               meta_we_o,
  input logic [MAX_OVF-1:0] ovf_valid_o,
  input logic               exc_o
);
  // R5
  full_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (!wr_en_o && !meta_we_o));

  // R2
  meta_with_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meta_we_o |-> wr_en_o);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!wr_en_o && !exc_o && !meta_we_o && dest_o == 2'd0));

  // R4
  alloc_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i ##1 (dest_o == 2'd3) |->
      $countones(ovf_valid_o) == $countones($past(ovf_valid_i)) + 1);

  // R3
  hit_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i ##1 (dest_o == 2'd2) |-> ovf_valid_o == $past(ovf_valid_i));

  // R2
  reg_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i ##1 (dest_o == 2'd1) |->
      $countones(ovf_valid_o) <= $countones($past(ovf_valid_i)));
endmodule

bind lcp_wb_ovf lcp_wb_ovf_chk #(.MAX_OVF(MAX_OVF)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .ovf_valid_i(ovf_valid_i),
  .wr_en_o    (wr_en_o),
  .dest_o     (dest_o),
  .meta_we_o  (meta_we_o),
  .ovf_valid_o(ovf_valid_o),
  .exc_o      (exc_o)
);

// File: tb/sim_lcp_wb_ovf.sv
module sim_lcp_wb_ovf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [5:0]  line_idx_i = '0;
  logic [6:0]  comp_size_i = '0;
  logic [1:0]  page_cls_i = '0;
  logic [1:0]  slot_cls_i = '0;
  logic [7:0]  ovf_valid_i = '0;
  logic [47:0] ovf_idx_i = '0;
  logic        wr_en_o, meta_we_o, exc_o;
  logic [1:0]  dest_o;
  logic [11:0] wr_off_o;
  logic [7:0]  ovf_valid_o;
  logic [47:0] ovf_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lcp_wb_ovf u0 (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] pg, input logic [1:0] sl, input logic [5:0] ln,
                       input logic [6:0] sz, input logic [7:0] v, input logic [47:0] ix);
    @(negedge clk_i);
    page_cls_i = pg; slot_cls_i = sl; line_idx_i = ln; comp_size_i = sz;
    ovf_valid_i = v; ovf_idx_i = ix; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  function automatic logic [47:0] put(input logic [47:0] a, input int k, input logic [5:0] ln);
    logic [47:0] r = a;
    r[k*6 +: 6] = ln;
    return r;
  endfunction

  task automatic t_reset();
    chk("R8", "wr_en", wr_en_o, 0);
    chk("R8", "dest", dest_o, 0);
    chk("R8", "off", wr_off_o, 0);
    chk("R8", "valid", ovf_valid_o, 0);
    chk("R8", "exc", exc_o, 0);
  endtask

  // 1 KiB page, 8 B slots: 7 overflow slots, base 576
  task automatic t_fit_plain();
    issue(2'd1, 2'd1, 6'd5, 7'd8, 8'h00, '0);
    chk("R1", "dest", dest_o, 1);
    chk("R1", "off", wr_off_o, 40);
    chk("R2", "meta_we", meta_we_o, 0);
    chk("R2", "valid", ovf_valid_o, 8'h00);
  endtask

  task automatic t_fit_release();
    issue(2'd1, 2'd1, 6'd5, 7'd3, 8'h04, put('0, 2, 6'd5));
    chk("R1", "dest", dest_o, 1);
    chk("R2", "valid", ovf_valid_o, 8'h00);
    chk("R2", "meta_we", meta_we_o, 1);
  endtask

  task automatic t_rewrite();
    logic [47:0] ix = put(put('0, 0, 6'd9), 2, 6'd5);
    issue(2'd1, 2'd1, 6'd5, 7'd20, 8'h05, ix);
    chk("R3", "dest", dest_o, 2);
    chk("R3", "off", wr_off_o, 704);
    chk("R3", "meta_we", meta_we_o, 0);
    chk("R3", "valid", ovf_valid_o, 8'h05);
    chk("R3", "idx", ovf_idx_o, ix);
  endtask

  task automatic t_alloc();
    logic [47:0] ix = put(put(put('0, 0, 6'd1), 1, 6'd2), 3, 6'd3);
    issue(2'd1, 2'd1, 6'd12, 7'd40, 8'h0B, ix);
    chk("R4", "dest", dest_o, 3);
    chk("R4", "off", wr_off_o, 704);
    chk("R4", "valid", ovf_valid_o, 8'h0F);
    chk("R4", "idx", ovf_idx_o, put(ix, 2, 6'd12));
    chk("R4", "meta_we", meta_we_o, 1);
  endtask

  task automatic t_full();
    issue(2'd1, 2'd1, 6'd30, 7'd64, 8'h7F, '0);
    chk("R5", "exc", exc_o, 1);
    chk("R5", "wr_en", wr_en_o, 0);
    chk("R5", "meta_we", meta_we_o, 0);
  endtask

  task automatic t_geometry();
    // 512 B page, 4 B slots: 3 slots, base 320
    issue(2'd0, 2'd0, 6'd1, 7'd10, 8'h03, '0);
    chk("R6", "off small", wr_off_o, 448);
    chk("R6", "dest small", dest_o, 3);
    issue(2'd0, 2'd0, 6'd1, 7'd10, 8'h07, '0);
    chk("R6", "exc small", exc_o, 1);
    // stale entry beyond count must not match
    issue(2'd0, 2'd0, 6'd7, 7'd10, 8'h20, put('0, 5, 6'd7));
    chk("R6", "stale dest", dest_o, 3);
    chk("R6", "stale valid", ovf_valid_o, 8'h21);
    // 4 KiB page, 32 B slots: capped at 8, base 2112
    issue(2'd3, 2'd3, 6'd4, 7'd50, 8'h7F, '0);
    chk("R6", "off cap", wr_off_o, 2560);
    chk("R6", "valid cap", ovf_valid_o, 8'hFF);
    // 512 B page, 8 B slots: no overflow region
    issue(2'd0, 2'd1, 6'd2, 7'd9, 8'h00, '0);
    chk("R6", "exc none", exc_o, 1);
    issue(2'd0, 2'd1, 6'd63, 7'd8, 8'h00, '0);
    chk("R1", "off edge", wr_off_o, 504);
  endtask

  task automatic t_idle();
    issue(2'd1, 2'd1, 6'd5, 7'd8, 8'h00, '0);
    @(negedge clk_i);
    chk("R7", "wr_en idle", wr_en_o, 0);
    chk("R7", "dest idle", dest_o, 0);
    chk("R7", "exc idle", exc_o, 0);
    @(negedge clk_i);
    line_idx_i = 6'd1; comp_size_i = 7'd1; req_valid_i = 1'b1;
    #1;
    chk("R7", "no early output", wr_en_o, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R7", "one-cycle output", wr_en_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_fit_plain();
    t_fit_release();
    t_rewrite();
    t_alloc();
    t_full();
    t_geometry();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule